// File: doc/BRIEF.md
# Control-Transfer Next-PC and Return-Link Unit

This block works out where the program counter goes after a control instruction of a 16-bit accumulator-free register machine. It takes the instruction word, the already-incremented PC, the register-file value that the instruction's base field selects, the branch-taken flag from the condition logic, and a read-data port from memory. It returns a registered PC-load strobe with the new PC value, and a registered write strobe with data for the return-link register R7.

A conditional branch, a PC-relative or register-based subroutine call, and a register jump (including return through R7) each resolve in one cycle. A system call takes two cycles. In the cycle it is accepted, the unit asks memory for one word of a 256-entry service table at the bottom of the address space. In the next cycle the unit is busy while that word comes back. In the cycle after that, it loads the PC with the returned word and writes the return address to R7. The target of every call is captured when the call is accepted, so a call whose base register is R7 jumps to the old R7 value and not to the return address that overwrites it.

Top module: `nxtpc_link_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, pc_load, link_we, busy and mem_req are all 0 (with ir_valid low).
- R2: An accepted instruction with opcode ir[15:12]=0000 (branch) gives pc_load=1 one cycle later. next_pc is pc_inc plus sign-extended ir[8:0] when br_taken=1, and pc_inc when br_taken=0. link_we stays 0.
- R3: An accepted instruction with opcode 0100 and ir[11]=1 (relative call) gives pc_load=1 one cycle later, with next_pc = pc_inc + sign-extended ir[10:0].
- R4: An accepted instruction with opcode 0100 and ir[11]=0 (register call) gives pc_load=1 one cycle later, with next_pc equal to base_val as sampled in the acceptance cycle (base_val is the register that ir[8:6] names).
- R5: Both call forms assert link_we together with pc_load, and link_data equals the pc_inc of the acceptance cycle. A register call through R7 (ir[8:6]=111) still targets the pre-link base_val, even if base_val changes afterwards.
- R6: An accepted instruction with opcode 1100 (jump, return when ir[8:6]=111) gives pc_load=1 one cycle later, with next_pc = base_val and link_we=0.
- R7: An accepted instruction with opcode 1111 (system call) drives mem_req=1 and mem_addr={8'h00, ir[7:0]} in its acceptance cycle.
- R8: A system call raises busy for exactly the next cycle, with pc_load=0 during that cycle. In the cycle after that, pc_load=1, next_pc is the mem_rdata word present during the busy cycle, link_we=1, and link_data is the pc_inc of the acceptance cycle.
- R9: While busy=1, ir_valid is ignored: mem_req stays 0, and the instruction leaves no pc_load or link_we in any later cycle.
- R10: Any other opcode, or ir_valid=0, gives pc_load=0, link_we=0 and mem_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_valid | input | 1 | An instruction is presented this cycle |
| ir | input | 16 | Instruction word |
| pc_inc | input | 16 | Address of the next sequential instruction |
| base_val | input | 16 | Register-file value of register ir[8:6] |
| br_taken | input | 1 | Branch condition is met |
| mem_rdata | input | 16 | Table word, valid the cycle after mem_req |
| busy | output | 1 | System-call table read in progress; input not accepted |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 16 | Table read address |
| pc_load | output | 1 | Load next_pc into the PC |
| next_pc | output | 16 | New PC value |
| link_we | output | 1 | Write link_data into R7 |
| link_data | output | 16 | Return address for R7 |

## Verification
A wrong target or offset extension shows on next_pc exactly one cycle after acceptance. The bench sweeps every branch and relative-call offset, so one bad sign bit is exposed at once. A sequencer that stays busy, or drops busy too early, shows within two cycles of a system call: busy stays high, pc_load comes a cycle early or late, or next_pc carries the stale marker that the bench memory model returns when no read was requested. A link value taken at the wrong time shows on link_data in the same cycle as the PC load. A request that leaks through while busy shows on mem_req in the busy cycle itself.

// File: rtl/nxtpc_pkg.sv
// Package for the next-PC unit.
// Holds the control opcode codes and the redirect class that the
// decoder hands to the output stage. Assumes a 4-bit opcode field.
package nxtpc_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_BRANCH = 4'b0000;
    localparam logic [OPC_W-1:0] OPC_CALL   = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_SYSC   = 4'b1111;

    typedef enum logic [2:0] {
        RD_NONE   = 3'd0,
        RD_BRANCH = 3'd1,
        RD_CALL   = 3'd2,
        RD_JUMP   = 3'd3,
        RD_SYSC   = 3'd4
    } redir_kind_t;

endpackage

// File: rtl/nxtpc_target_calc.sv
// Target calculator.
// Combinational. Classifies the instruction word as a control transfer
// and forms the candidate target: branch offset, relative call offset or
// register base. Assumes the opcode sits in the top OPC_W bits of ir and
// that base_val already holds the register named by the base field.
module nxtpc_target_calc
    import nxtpc_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int BR_OFF_W = 9,
    parameter int CL_OFF_W = 11
) (
    input  logic [WORD_W-1:0] ir,
    input  logic [WORD_W-1:0] pc_inc,
    input  logic [WORD_W-1:0] base_val,
    input  logic              br_taken,
    output redir_kind_t       kind,
    output logic [WORD_W-1:0] target
);

    localparam int MODE_BIT = CL_OFF_W;

    logic [OPC_W-1:0]  opcode;
    logic [WORD_W-1:0] br_off;
    logic [WORD_W-1:0] cl_off;
    logic [WORD_W-1:0] br_dest;
    logic [WORD_W-1:0] cl_dest;

    // Field extraction and sign extension of both offsets.
    always_comb begin
        opcode = ir[WORD_W-1 -: OPC_W];
        br_off = {{(WORD_W-BR_OFF_W){ir[BR_OFF_W-1]}}, ir[BR_OFF_W-1:0]};
        cl_off = {{(WORD_W-CL_OFF_W){ir[CL_OFF_W-1]}}, ir[CL_OFF_W-1:0]};
        br_dest = pc_inc + br_off;
        cl_dest = pc_inc + cl_off;
    end

    // Class selection and target mux.
    always_comb begin
        kind   = RD_NONE;
        target = pc_inc;
        case (opcode)
            OPC_BRANCH: begin
                kind   = RD_BRANCH;
                target = br_taken ? br_dest : pc_inc;
            end
            OPC_CALL: begin
                kind   = RD_CALL;
                target = ir[MODE_BIT] ? cl_dest : base_val;
            end
            OPC_JUMP: begin
                kind   = RD_JUMP;
                target = base_val;
            end
            OPC_SYSC: begin
                kind   = RD_SYSC;
                target = pc_inc;
            end
            default: begin
                kind   = RD_NONE;
                target = pc_inc;
            end
        endcase
    end

endmodule

// File: rtl/nxtpc_trap_seq.sv
// System-call sequencer.
// On start it issues one table read at VEC_BASE plus the zero-extended
// vector, holds busy for one cycle while the word returns, and keeps the
// return address for the link write. Assumes memory returns read data on
// the cycle after the request.
module nxtpc_trap_seq #(
    parameter int                WORD_W   = 16,
    parameter int                VEC_W    = 8,
    parameter logic [WORD_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VEC_W-1:0]  vec,
    input  logic [WORD_W-1:0] pc_inc,
    output logic              busy,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] ret_addr
);

    logic              busy_q;
    logic [WORD_W-1:0] ret_q;

    // Request and table address for the accepted call.
    always_comb begin
        mem_req  = start;
        mem_addr = VEC_BASE + {{(WORD_W-VEC_W){1'b0}}, vec};
    end

    // Busy flag: high for exactly the cycle after start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else begin
            busy_q <= start;
        end
    end

    // Keep the return address captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (start) begin
            ret_q <= pc_inc;
        end
    end

    assign busy     = busy_q;
    assign ret_addr = ret_q;

endmodule

// File: rtl/nxtpc_out_stage.sv
// Output register stage.
// Registers the PC load and link write for one cycle after acceptance.
// A finishing system call loads the table word. The target is captured
// here at acceptance, so a later R7 write cannot alter it. Assumes accept
// and sysc_done never coincide.
module nxtpc_out_stage
    import nxtpc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  redir_kind_t       kind,
    input  logic [WORD_W-1:0] target,
    input  logic [WORD_W-1:0] pc_inc,
    input  logic              sysc_done,
    input  logic [WORD_W-1:0] handler,
    input  logic [WORD_W-1:0] sysc_ret,
    output logic              pc_load,
    output logic [WORD_W-1:0] next_pc,
    output logic              link_we,
    output logic [WORD_W-1:0] link_data
);

    // One-cycle load and link strobes with their data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load   <= 1'b0;
            next_pc   <= '0;
            link_we   <= 1'b0;
            link_data <= '0;
        end else begin
            pc_load <= 1'b0;
            link_we <= 1'b0;
            if (sysc_done) begin
                pc_load   <= 1'b1;
                next_pc   <= handler;
                link_we   <= 1'b1;
                link_data <= sysc_ret;
            end else if (accept) begin
                case (kind)
                    RD_BRANCH, RD_JUMP: begin
                        pc_load <= 1'b1;
                        next_pc <= target;
                    end
                    RD_CALL: begin
                        pc_load   <= 1'b1;
                        next_pc   <= target;
                        link_we   <= 1'b1;
                        link_data <= pc_inc;
                    end
                    default: begin
                        pc_load <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/nxtpc_link_unit.sv
// Next-PC and return-link unit (top).
// Accepts one instruction per cycle while not busy. It resolves branch,
// call and jump in one cycle and a system call in two, through a
// vector-table read. Assumes base_val is the register that ir[8:6] names
// and that the caller holds off redirects while pc_load is pending.
module nxtpc_link_unit
    import nxtpc_pkg::*;
#(
    parameter int                WORD_W   = 16,
    parameter int                VEC_W    = 8,
    parameter logic [WORD_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_valid,
    input  logic [WORD_W-1:0] ir,
    input  logic [WORD_W-1:0] pc_inc,
    input  logic [WORD_W-1:0] base_val,
    input  logic              br_taken,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    output logic              pc_load,
    output logic [WORD_W-1:0] next_pc,
    output logic              link_we,
    output logic [WORD_W-1:0] link_data
);

    redir_kind_t       kind;
    logic [WORD_W-1:0] target;
    logic              accept;
    logic              sysc_start;
    logic [WORD_W-1:0] sysc_ret;

    // Acceptance gating: nothing enters while the table read is pending.
    always_comb begin
        accept     = ir_valid && !busy;
        sysc_start = accept && (kind == RD_SYSC);
    end

    nxtpc_target_calc #(
        .WORD_W (WORD_W)
    ) u_calc (
        .ir       (ir),
        .pc_inc   (pc_inc),
        .base_val (base_val),
        .br_taken (br_taken),
        .kind     (kind),
        .target   (target)
    );

    nxtpc_trap_seq #(
        .WORD_W   (WORD_W),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (sysc_start),
        .vec      (ir[VEC_W-1:0]),
        .pc_inc   (pc_inc),
        .busy     (busy),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .ret_addr (sysc_ret)
    );

    nxtpc_out_stage #(
        .WORD_W (WORD_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .kind      (kind),
        .target    (target),
        .pc_inc    (pc_inc),
        .sysc_done (busy),
        .handler   (mem_rdata),
        .sysc_ret  (sysc_ret),
        .pc_load   (pc_load),
        .next_pc   (next_pc),
        .link_we   (link_we),
        .link_data (link_data)
    );

endmodule

// File: rtl/nxtpc_link_unit_chk.sv
// Port-level checker for the next-PC unit, bound to every instance.
module nxtpc_link_unit_chk #(
    parameter int WORD_W = 16,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              mem_req,
    input logic [WORD_W-1:0] mem_addr,
    input logic              pc_load,
    input logic              link_we
);

    AST_REQ_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> busy);  // R8

    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);  // R8

    AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pc_load);  // R8

    AST_BUSY_END_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (pc_load && link_we));  // R8

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_req);  // R9

    AST_LINK_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> pc_load);  // R5

    AST_TABLE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[WORD_W-1:VEC_W] == '0));  // R7

endmodule

bind nxtpc_link_unit nxtpc_link_unit_chk #(
    .WORD_W (WORD_W),
    .VEC_W  (VEC_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_addr (mem_addr),
    .pc_load  (pc_load),
    .link_we  (link_we)
);

// File: tb/sim_nxtpc_link_unit.sv
module sim_nxtpc_link_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_valid = 1'b0;
    logic [15:0] ir = '0;
    logic [15:0] pc_inc = '0;
    logic [15:0] base_val = '0;
    logic        br_taken = 1'b0;
    logic [15:0] mem_rdata = 16'hDEAD;
    logic        busy, mem_req, pc_load, link_we;
    logic [15:0] mem_addr, next_pc, link_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nxtpc_link_unit u0 (
        .clk(clk), .rst_n(rst_n), .ir_valid(ir_valid), .ir(ir),
        .pc_inc(pc_inc), .base_val(base_val), .br_taken(br_taken),
        .mem_rdata(mem_rdata), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .pc_load(pc_load), .next_pc(next_pc),
        .link_we(link_we), .link_data(link_data)
    );

    function automatic logic [15:0] tbl(input logic [15:0] a);
        return 16'((32'h0400 + 32'(a) * 32'h0013) ^ 32'h5A00);
    endfunction

    // Table memory model: one-cycle read latency, marker when idle.
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= tbl(mem_addr);
        else         mem_rdata <= 16'hDEAD;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [15:0] i, input logic [15:0] p,
                         input logic [15:0] b, input logic t);
        ir_valid = 1'b1; ir = i; pc_inc = p; base_val = b; br_taken = t;
    endtask

    // One-cycle control instruction: expected load, target and link.
    task automatic one_cycle(input string req, input logic [15:0] i, input logic [15:0] p,
                             input logic [15:0] b, input logic t,
                             input logic exp_load, input logic [15:0] exp_pc,
                             input logic exp_link);
        issue(i, p, b, t);
        #1;
        check({req, " mem_req"}, 32'(mem_req), 32'd0);
        step();
        check({req, " pc_load"}, 32'(pc_load), 32'(exp_load));
        if (exp_load) check({req, " next_pc"}, 32'(next_pc), 32'(exp_pc));
        check({req, " link_we"}, 32'(link_we), 32'(exp_link));
        if (exp_link) check({req, " link_data"}, 32'(link_data), 32'(p));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pc_load", 32'(pc_load), 0);
        check("R1 link_we", 32'(link_we), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;
        step();
        check("R1 post pc_load", 32'(pc_load), 0);
        check("R1 post busy", 32'(busy), 0);

        // R2: every branch offset, taken and not taken
        for (int o = 0; o < 512; o++) begin
            logic [15:0] p, e;
            logic tk;
            p  = 16'(32'h3000 + o * 7);
            tk = o[0] ^ o[3];
            e  = tk ? 16'(p + {{7{o[8]}}, o[8:0]}) : p;
            one_cycle("R2", {4'b0000, 3'b111, o[8:0]}, p, 16'h1111, tk, 1'b1, e, 1'b0);
        end

        // R3/R5: every relative call offset
        for (int o = 0; o < 2048; o++) begin
            logic [15:0] p, e;
            p = 16'(32'h8000 ^ (o * 13));
            e = 16'(p + {{5{o[10]}}, o[10:0]});
            one_cycle("R3", {4'b0100, 1'b1, o[10:0]}, p, 16'h2222, 1'b0, 1'b1, e, 1'b1);
        end

        // R4/R5: register calls over all base fields
        for (int r = 0; r < 8; r++) begin
            for (int v = 0; v < 4; v++) begin
                logic [15:0] b;
                b = 16'(32'h1357 * (v + 1) + r);
                one_cycle("R4", {4'b0100, 1'b0, 2'b00, r[2:0], 6'b0}, 16'h4001, b, 1'b0, 1'b1, b, 1'b1);
            end
        end

        // R5: call through R7; target must hold the pre-link value
        one_cycle("R5", {4'b0100, 1'b0, 2'b00, 3'b111, 6'b0}, 16'h5010, 16'hABCD, 1'b0, 1'b1, 16'hABCD, 1'b1);
        ir_valid = 1'b0; base_val = 16'h5010;
        step();
        check("R5 target kept", 32'(next_pc), 32'hABCD);
        check("R5 single pulse", 32'(pc_load), 0);

        // R6: jumps and return
        for (int r = 0; r < 8; r++) begin
            logic [15:0] b;
            b = 16'(32'h0F0F + r * 32'h1001);
            one_cycle("R6", {4'b1100, 3'b000, r[2:0], 6'b0}, 16'h6000, b, 1'b1, 1'b1, b, 1'b0);
        end

        // R10: non-control opcodes and idle cycles
        for (int op = 0; op < 16; op++) begin
            if (op == 0 || op == 4 || op == 12 || op == 15) continue;
            one_cycle("R10", {op[3:0], 12'hFA5}, 16'h7000, 16'h7777, 1'b1, 1'b0, 16'h0, 1'b0);
        end
        ir_valid = 1'b0; ir = 16'h4FFF;
        step();
        check("R10 idle pc_load", 32'(pc_load), 0);
        check("R10 idle link_we", 32'(link_we), 0);

        // R7/R8/R9: every system-call vector
        for (int v = 0; v < 256; v++) begin
            logic [15:0] p;
            p = 16'(32'h3000 + v * 5);
            issue({4'b1111, 4'b0000, v[7:0]}, p, 16'h0BAD, 1'b0);
            #1;
            check("R7 mem_req", 32'(mem_req), 1);
            check("R7 mem_addr", 32'(mem_addr), 32'(v[7:0]));
            step();
            check("R8 busy", 32'(busy), 1);
            check("R8 no load while busy", 32'(pc_load), 0);
            // R9: junk call presented while busy must be dropped
            issue({4'b1111, 4'b0000, ~v[7:0]}, 16'hEEEE, 16'h0BAD, 1'b0);
            #1;
            check("R9 mem_req while busy", 32'(mem_req), 0);
            step();
            check("R8 busy drop", 32'(busy), 0);
            check("R8 pc_load", 32'(pc_load), 1);
            check("R8 next_pc", 32'(next_pc), 32'(tbl(16'(v))));
            check("R8 link_we", 32'(link_we), 1);
            check("R8 link_data", 32'(link_data), 32'(p));
            ir_valid = 1'b0;
            step();
            check("R9 no late load", 32'(pc_load), 0);
            check("R9 not busy", 32'(busy), 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule